// File: doc/BRIEF.md
# Trellis Add-Compare-Select Step Engine

This block performs one trellis step of add-compare-select for a rate 1/N convolutional decoder. It works on a 16-state trellis (constraint length 5) or a 64-state trellis (constraint length 7), chosen by a mode input each time a step starts. The path metrics live in an external single-word memory that the block reads and writes itself. The branch metrics arrive as one packed vector with one signed metric per butterfly. The survivor decisions leave as one packed vector with one bit per new state, ready for a separate traceback store.

The block keeps the larger metric rather than the smaller one. All candidate sums are signed 16-bit saturating values. Once started, the engine reads every old metric into a local copy and splits the states into even and odd operands. It then runs a configurable number of butterflies per clock and writes the new metrics back in place. It pulses done after the last write. Branch metric generation, metric normalization and traceback are left to other blocks.

Top module: `trellis_acs_step`

## Requirements
- R1: Every candidate sum and difference is formed in signed 16-bit arithmetic that saturates at +32767 and -32768 instead of wrapping.
- R2: Butterfly j takes its first operand A from stored state 2j (even) and its second operand B from stored state 2j+1 (odd).
- R3: With branch metric M of butterfly j and state count S, new state j receives max(A+M, B-M) and new state j+S/2 receives max(A-M, B+M).
- R4: Bit k of dec_out is the decision for new state k. It is 1 when the first candidate (A+M for k<S/2, A-M otherwise) is greater than or equal to the second, so a tie yields 1.
- R5: The mode_64 input, sampled with an accepted start, selects 64 states and 32 butterflies when 1, and 16 states and 8 butterflies when 0. In 16-state mode only addresses 0..15 are read or written, only branch lanes 0..7 are used, and dec_out[63:16] is 0.
- R6: The memory has one cycle of read latency: data for an address driven with pm_rd_en appears on pm_rd_data in the next cycle. A step reads each of the S addresses exactly once and writes each of them exactly once. All reads come before the first write, and a read and a write never occur in the same cycle.
- R7: done is a single-cycle pulse that comes after the last write of a step. dec_out then holds its value until the next accepted start.
- R8: A start pulse while busy is 1 is ignored and does not change the running step or add another one.
- R9: Branch lane j occupies bm_in[16j+15:16j]. bm_in and mode_64 are captured only on the accepted start, so later changes during the step have no effect.
- R10: After reset, busy, done, pm_rd_en and pm_wr_en are 0 and dec_out is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a trellis step when idle |
| mode_64 | input | 1 | 1 selects 64 states, 0 selects 16 states |
| bm_in | input | 512 | Signed branch metric per butterfly, lane j at bits 16j+15:16j |
| pm_rd_en | output | 1 | Path metric memory read strobe |
| pm_rd_addr | output | 6 | Path metric read address |
| pm_rd_data | input | 16 | Read data, valid one cycle after the strobe |
| pm_wr_en | output | 1 | Path metric memory write strobe |
| pm_wr_addr | output | 6 | Path metric write address |
| pm_wr_data | output | 16 | New path metric to store |
| dec_out | output | 64 | Survivor decisions, bit k for new state k |
| busy | output | 1 | A step is in progress |
| done | output | 1 | One-cycle pulse when the step has completed |

## Verification
The bench drives all-equal metrics with zero branch metrics, where every comparison is a tie. A design that breaks ties toward the second candidate would clear decision bits there. It also loads metrics close to both signed limits with large branch metrics of each sign. A wrapping adder would then pick the wrong survivor and store a metric of the wrong sign. In 16-state steps it checks that memory words 16..63 and the upper decision bits stay untouched, which exposes the wrong half-offset or a wrong butterfly count. A deliberate restart with a new mode and new branch metrics in the middle of a step shows whether inputs are re-sampled, and an out-of-order write would make a later butterfly read an already updated metric.

// File: rtl/acs_pkg.sv
package acs_pkg;

    // Phases of one trellis step
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // waiting for start
        PH_LOAD  = 2'd1,   // fetching old metrics into the local copy
        PH_CALC  = 2'd2,   // butterflies, LANES per clock
        PH_STORE = 2'd3    // writing new metrics back in place
    } phase_e;

endpackage

// File: rtl/acs_butterfly.sv
// One radix-2 butterfly: two saturating candidate pairs, maximum select,
// ties resolved toward the first candidate.
module acs_butterfly #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] op_even,
    input  logic signed [W-1:0] op_odd,
    input  logic signed [W-1:0] bm,
    output logic signed [W-1:0] pm_upper,
    output logic signed [W-1:0] pm_lower,
    output logic                dec_upper,
    output logic                dec_lower
);
    localparam logic signed [W:0] POS_LIM = {2'b00, {(W-1){1'b1}}};
    localparam logic signed [W:0] NEG_LIM = {2'b11, {(W-1){1'b0}}};

    function automatic logic signed [W-1:0] clamp(input logic signed [W:0] s);
        if (s > POS_LIM)      return POS_LIM[W-1:0];
        else if (s < NEG_LIM) return NEG_LIM[W-1:0];
        else                  return s[W-1:0];
    endfunction

    logic signed [W:0]   even_x, odd_x, bm_x;
    logic signed [W:0]   s_ep, s_om, s_em, s_op;
    logic signed [W-1:0] c_ep, c_om, c_em, c_op;

    always_comb begin
        even_x = {op_even[W-1], op_even};
        odd_x  = {op_odd[W-1],  op_odd};
        bm_x   = {bm[W-1],      bm};
        s_ep   = even_x + bm_x;
        s_om   = odd_x  - bm_x;
        s_em   = even_x - bm_x;
        s_op   = odd_x  + bm_x;
        c_ep   = clamp(s_ep);
        c_om   = clamp(s_om);
        c_em   = clamp(s_em);
        c_op   = clamp(s_op);
        dec_upper = (c_ep >= c_om);
        dec_lower = (c_em >= c_op);
        pm_upper  = dec_upper ? c_ep : c_om;
        pm_lower  = dec_lower ? c_em : c_op;
    end

endmodule

// File: rtl/acs_lane_array.sv
// LANES butterflies working on butterfly group grp: lane l handles
// butterfly index grp*LANES+l and fetches its even/odd operands.
module acs_lane_array #(
    parameter int W          = 16,
    parameter int STATES_MAX = 64,
    parameter int LANES      = 4,
    parameter int CW         = 7
) (
    input  logic [STATES_MAX*W-1:0]       old_pm,
    input  logic [STATES_MAX/2*W-1:0]     bm_vec,
    input  logic [CW-1:0]                 grp,
    output logic [LANES-1:0][W-1:0]       lane_upper,
    output logic [LANES-1:0][W-1:0]       lane_lower,
    output logic [LANES-1:0]              lane_dec_upper,
    output logic [LANES-1:0]              lane_dec_lower,
    output logic [LANES-1:0][$clog2(STATES_MAX)-2:0] lane_idx
);
    localparam int IDXW  = $clog2(STATES_MAX);
    localparam int BIDXW = IDXW - 1;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BIDXW-1:0]    bf_idx;
        logic [IDXW-1:0]     even_addr, odd_addr;
        logic signed [W-1:0] a_op, b_op, m_op, up, lo;
        logic                du, dl;

        assign bf_idx    = BIDXW'(int'(grp) * LANES + l);
        assign even_addr = {bf_idx, 1'b0};
        assign odd_addr  = {bf_idx, 1'b1};
        assign a_op      = old_pm[even_addr*W +: W];
        assign b_op      = old_pm[odd_addr*W +: W];
        assign m_op      = bm_vec[bf_idx*W +: W];

        acs_butterfly #(.W(W)) u_bf (
            .op_even   (a_op),
            .op_odd    (b_op),
            .bm        (m_op),
            .pm_upper  (up),
            .pm_lower  (lo),
            .dec_upper (du),
            .dec_lower (dl)
        );

        assign lane_upper[l]     = up;
        assign lane_lower[l]     = lo;
        assign lane_dec_upper[l] = du;
        assign lane_dec_lower[l] = dl;
        assign lane_idx[l]       = bf_idx;
    end

endmodule

// File: rtl/trellis_acs_step.sv
// One add-compare-select trellis step over an external path metric memory.
// LANES must divide STATES_MIN/2.
module trellis_acs_step
    import acs_pkg::*;
#(
    parameter int W          = 16,
    parameter int STATES_MAX = 64,
    parameter int STATES_MIN = 16,
    parameter int LANES      = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              mode_64,
    input  logic [STATES_MAX/2*W-1:0]         bm_in,
    output logic                              pm_rd_en,
    output logic [$clog2(STATES_MAX)-1:0]     pm_rd_addr,
    input  logic [W-1:0]                      pm_rd_data,
    output logic                              pm_wr_en,
    output logic [$clog2(STATES_MAX)-1:0]     pm_wr_addr,
    output logic [W-1:0]                      pm_wr_data,
    output logic [STATES_MAX-1:0]             dec_out,
    output logic                              busy,
    output logic                              done
);
    localparam int BF_MAX    = STATES_MAX / 2;
    localparam int IDXW      = $clog2(STATES_MAX);
    localparam int BIDXW     = IDXW - 1;
    localparam int CW        = $clog2(STATES_MAX + 1);
    localparam int GRP_BIG   = STATES_MAX / (2 * LANES);
    localparam int GRP_SMALL = STATES_MIN / (2 * LANES);

    typedef struct packed {
        phase_e                  phase;
        logic                    big;
        logic [CW-1:0]           cnt;
        logic                    pend;
        logic [IDXW-1:0]         pend_addr;
        logic [BF_MAX*W-1:0]     bm;
        logic [STATES_MAX*W-1:0] old_pm;
        logic [STATES_MAX*W-1:0] new_pm;
        logic [STATES_MAX-1:0]   dec;
        logic                    done;
    } step_state_t;

    step_state_t q, d;

    logic [LANES-1:0][W-1:0]     lane_upper, lane_lower;
    logic [LANES-1:0]            lane_dec_upper, lane_dec_lower;
    logic [LANES-1:0][BIDXW-1:0] lane_idx;

    logic [CW-1:0]   n_states, n_groups;
    logic [IDXW-1:0] last_addr;
    int              half_n;

    acs_lane_array #(
        .W          (W),
        .STATES_MAX (STATES_MAX),
        .LANES      (LANES),
        .CW         (CW)
    ) u_lanes (
        .old_pm         (q.old_pm),
        .bm_vec         (q.bm),
        .grp            (q.cnt),
        .lane_upper     (lane_upper),
        .lane_lower     (lane_lower),
        .lane_dec_upper (lane_dec_upper),
        .lane_dec_lower (lane_dec_lower),
        .lane_idx       (lane_idx)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        n_states   = q.big ? CW'(STATES_MAX) : CW'(STATES_MIN);
        n_groups   = q.big ? CW'(GRP_BIG)    : CW'(GRP_SMALL);
        half_n     = q.big ? BF_MAX          : STATES_MIN / 2;
        last_addr  = IDXW'(n_states - 1'b1);
        pm_rd_en   = 1'b0;
        pm_rd_addr = q.cnt[IDXW-1:0];
        pm_wr_en   = 1'b0;
        pm_wr_addr = q.cnt[IDXW-1:0];
        pm_wr_data = q.new_pm[q.cnt[IDXW-1:0]*W +: W];

        unique case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.phase = PH_LOAD;
                    d.big   = mode_64;
                    d.bm    = bm_in;
                    d.cnt   = '0;
                    d.pend  = 1'b0;
                    d.dec   = '0;
                end
            end
            PH_LOAD: begin
                // issue one read per cycle, capture one cycle later
                if (q.cnt < n_states) begin
                    pm_rd_en    = 1'b1;
                    d.pend      = 1'b1;
                    d.pend_addr = q.cnt[IDXW-1:0];
                    d.cnt       = q.cnt + 1'b1;
                end else begin
                    d.pend = 1'b0;
                end
                if (q.pend) begin
                    d.old_pm[q.pend_addr*W +: W] = pm_rd_data;
                    if (q.pend_addr == last_addr) begin
                        d.phase = PH_CALC;
                        d.cnt   = '0;
                        d.pend  = 1'b0;
                    end
                end
            end
            PH_CALC: begin
                for (int l = 0; l < LANES; l++) begin
                    d.new_pm[int'(lane_idx[l])*W +: W]            = lane_upper[l];
                    d.new_pm[(int'(lane_idx[l]) + half_n)*W +: W] = lane_lower[l];
                    d.dec[int'(lane_idx[l])]                      = lane_dec_upper[l];
                    d.dec[int'(lane_idx[l]) + half_n]             = lane_dec_lower[l];
                end
                if (q.cnt == n_groups - 1'b1) begin
                    d.phase = PH_STORE;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_STORE: begin
                pm_wr_en = 1'b1;
                if (q.cnt == n_states - 1'b1) begin
                    d.phase = PH_IDLE;
                    d.cnt   = '0;
                    d.done  = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dec_out = q.dec;
    assign busy    = (q.phase != PH_IDLE);
    assign done    = q.done;

endmodule

// File: rtl/acs_step_chk.sv
module acs_step_chk #(
    parameter int STATES_MAX = 64,
    parameter int STATES_MIN = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start,
    input logic                          mode_64,
    input logic                          busy,
    input logic                          done,
    input logic                          pm_rd_en,
    input logic [$clog2(STATES_MAX)-1:0] pm_rd_addr,
    input logic                          pm_wr_en,
    input logic [$clog2(STATES_MAX)-1:0] pm_wr_addr,
    input logic [STATES_MAX-1:0]         dec_out
);
    logic wrote_q;
    logic small_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrote_q <= 1'b0;
            small_q <= 1'b0;
        end else if (start && !busy) begin
            wrote_q <= 1'b0;
            small_q <= !mode_64;
        end else if (pm_wr_en) begin
            wrote_q <= 1'b1;
        end
    end

    AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wrote_q |-> !pm_rd_en); // R6
    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pm_rd_en && pm_wr_en)); // R6
    AST_SMALL_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (small_q && pm_rd_en) |-> (int'(pm_rd_addr) < STATES_MIN)); // R5
    AST_SMALL_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (small_q && pm_wr_en) |-> (int'(pm_wr_addr) < STATES_MIN)); // R5
    AST_SMALL_DEC_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (small_q && done) |-> ((dec_out >> STATES_MIN) == '0)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(dec_out)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pm_rd_en && !pm_wr_en)); // R10

endmodule

bind trellis_acs_step acs_step_chk #(
    .STATES_MAX (STATES_MAX),
    .STATES_MIN (STATES_MIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_64    (mode_64),
    .busy       (busy),
    .done       (done),
    .pm_rd_en   (pm_rd_en),
    .pm_rd_addr (pm_rd_addr),
    .pm_wr_en   (pm_wr_en),
    .pm_wr_addr (pm_wr_addr),
    .dec_out    (dec_out)
);

// File: tb/sim_trellis_acs_step.sv
module sim_trellis_acs_step;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         mode_64 = 1'b0;
    logic [511:0] bm_in = '0;
    logic         pm_rd_en, pm_wr_en;
    logic [5:0]   pm_rd_addr, pm_wr_addr;
    logic [15:0]  pm_rd_data;
    logic [15:0]  pm_wr_data;
    logic [63:0]  dec_out;
    logic         busy, done;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trellis_acs_step u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_64(mode_64),
        .bm_in(bm_in), .pm_rd_en(pm_rd_en), .pm_rd_addr(pm_rd_addr),
        .pm_rd_data(pm_rd_data), .pm_wr_en(pm_wr_en), .pm_wr_addr(pm_wr_addr),
        .pm_wr_data(pm_wr_data), .dec_out(dec_out), .busy(busy), .done(done)
    );

    // external path metric memory, one cycle read latency
    logic [15:0] mem [64];
    always @(posedge clk) begin
        if (pm_rd_en) pm_rd_data <= mem[pm_rd_addr];
        if (pm_wr_en) mem[pm_wr_addr] <= pm_wr_data;
    end

    typedef struct packed {
        logic [63:0]   dec;
        logic [1023:0] pm;
        logic [6:0]    n;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    done_cnt = 0;
    logic [63:0] last_dec = '0;

    function automatic int sat16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Driver: build expected result, then launch the step
    task automatic run_step(input bit big, input logic [511:0] bm, input string tag,
                            input bit disturb);
        exp_t e;
        int s, h;
        s = big ? 64 : 16;
        h = s / 2;
        e.dec = '0;
        e.n   = 7'(s);
        for (int i = 0; i < 64; i++) e.pm[i*16 +: 16] = mem[i];
        for (int j = 0; j < h; j++) begin
            int a, b, m, c0, c1, c2, c3;
            a  = int'($signed(mem[2*j]));
            b  = int'($signed(mem[2*j+1]));
            m  = int'($signed(bm[j*16 +: 16]));
            c0 = sat16(a + m); c1 = sat16(b - m);
            c2 = sat16(a - m); c3 = sat16(b + m);
            e.dec[j]     = (c0 >= c1);
            e.dec[j + h] = (c2 >= c3);
            e.pm[j*16 +: 16]       = 16'((c0 >= c1) ? c0 : c1);
            e.pm[(j + h)*16 +: 16] = 16'((c2 >= c3) ? c2 : c3);
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b1; mode_64 = big; bm_in = bm;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (5) @(negedge clk);
            start = 1'b1; mode_64 = !big; bm_in = ~bm;
            @(negedge clk);
            start = 1'b0;
            bm_in = {16{$urandom()}};
        end
        do @(negedge clk); while (!done);
        @(negedge clk);
    endtask

    // Monitor: scoreboard pops expectations when done pulses
    int  rd_cnt = 0, wr_cnt = 0;
    bit  wrote = 1'b0, order_bad = 1'b0, prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pm_rd_en) begin rd_cnt++; if (wrote) order_bad = 1'b1; end
            if (pm_rd_en && pm_wr_en) order_bad = 1'b1;
            if (pm_wr_en) begin wr_cnt++; wrote = 1'b1; end
            if (done && prev_done) begin
                tests++; fails++;
                $display("FAIL R7 done high two cycles: actual 1 expected 0");
            end
            if (done) begin
                exp_t  e;
                string t;
                int    bad, first;
                done_cnt++;
                if (exp_q.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R8 unexpected done: actual 1 expected 0");
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    last_dec = e.dec;
                    tests++;
                    if (dec_out !== e.dec) begin
                        fails++;
                        $display("FAIL R4 %s decisions: actual %h expected %h", t, dec_out, e.dec);
                    end
                    bad = 0; first = -1;
                    for (int i = 0; i < 64; i++)
                        if (mem[i] !== e.pm[i*16 +: 16]) begin bad++; if (first < 0) first = i; end
                    tests++;
                    if (bad != 0) begin
                        fails++;
                        $display("FAIL R3 %s metrics: state %0d actual %h expected %h (%0d wrong)",
                                 t, first, mem[first], e.pm[first*16 +: 16], bad);
                    end
                    tests++;
                    if (rd_cnt != int'(e.n) || wr_cnt != int'(e.n) || order_bad) begin
                        fails++;
                        $display("FAIL R6 %s access: reads %0d writes %0d order_bad %0d expected %0d/%0d/0",
                                 t, rd_cnt, wr_cnt, order_bad, e.n, e.n);
                    end
                end
                rd_cnt = 0; wr_cnt = 0; wrote = 1'b0; order_bad = 1'b0;
            end
            prev_done = done;
        end
    end

    task automatic check(input bit ok, input string msg, input logic [63:0] act,
                         input logic [63:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", msg, act, expv);
        end
    endtask

    function automatic logic [511:0] bm_fill(input int v);
        logic [511:0] r;
        for (int j = 0; j < 32; j++) r[j*16 +: 16] = 16'(v);
        return r;
    endfunction

    function automatic logic [511:0] bm_rand(input int lim);
        logic [511:0] r;
        for (int j = 0; j < 32; j++)
            r[j*16 +: 16] = 16'(int'($urandom_range(2*lim, 0)) - lim);
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [511:0] bm;
        int dc;
        for (int i = 0; i < 64; i++) mem[i] = 16'd0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!busy && !done && !pm_rd_en && !pm_wr_en, "R10 reset controls",
              {60'd0, busy, done, pm_rd_en, pm_wr_en}, 64'd0);
        check(dec_out == 64'd0, "R10 reset decisions", dec_out, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 ties: all metrics equal, zero branch metric
        for (int i = 0; i < 64; i++) mem[i] = 16'd100;
        run_step(1'b0, '0, "R4 tie 16-state", 1'b0);
        for (int i = 0; i < 64; i++) mem[i] = 16'd7;
        run_step(1'b1, '0, "R4 tie 64-state", 1'b0);

        // R2: odd states dominate, distinct values per state
        for (int i = 0; i < 64; i++) mem[i] = 16'((i % 2) ? 1000 + 10*i : -(10*i));
        run_step(1'b1, bm_fill(3), "R2 even/odd split", 1'b0);

        // R1: saturation at both limits, both branch signs
        for (int i = 0; i < 64; i++) mem[i] = (i % 2) ? 16'(-32000) : 16'(32000);
        run_step(1'b1, bm_fill(2000), "R1 saturate positive bm", 1'b0);
        for (int i = 0; i < 64; i++) mem[i] = (i % 2) ? 16'(-32000) : 16'(32000);
        run_step(1'b1, bm_fill(-2000), "R1 saturate negative bm", 1'b0);
        for (int i = 0; i < 64; i++) mem[i] = (i % 2) ? 16'(32767) : 16'(-32768);
        run_step(1'b0, bm_fill(32767), "R1 saturate extremes", 1'b0);

        // R5: 16-state steps leave upper memory untouched, lanes 8..31 unused
        for (int i = 0; i < 64; i++) mem[i] = 16'($urandom_range(4000, 0));
        bm = bm_rand(500);
        bm[511:128] = {24{16'h7FFF}};
        run_step(1'b0, bm, "R5 small mode", 1'b0);
        check(dec_out[63:16] == 48'd0, "R5 upper decisions", dec_out, 64'd0);

        // R3: several random 64-state and 16-state steps chained in place
        for (int k = 0; k < 6; k++)
            run_step(k % 3 != 0, bm_rand(3000), "R3 random step", 1'b0);

        // R8 and R9: restart with other mode and metrics mid-step is ignored
        for (int i = 0; i < 64; i++) mem[i] = 16'($urandom_range(2000, 0));
        dc = done_cnt;
        run_step(1'b0, bm_rand(800), "R8 R9 disturbed small", 1'b1);
        run_step(1'b1, bm_rand(800), "R8 R9 disturbed big", 1'b1);
        repeat (200) @(negedge clk);
        check(done_cnt == dc + 2, "R8 done count", 64'(done_cnt - dc), 64'd2);

        // R7: decisions held while idle
        check(dec_out == last_dec, "R7 decisions held", dec_out, last_dec);
        check(!busy && !done, "R7 idle after step", {62'd0, busy, done}, 64'd0);
        check(exp_q.size() == 0, "R7 all steps completed", 64'(exp_q.size()), 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule